// File: doc/BRIEF.md
# Opcode-Menu SPI Flash Cycle Sequencer

This block is a register-mapped SPI flash master. It can only send commands that software has first placed in an eight-entry opcode menu. Each menu entry has a 2-bit type code. The type tells the block whether a 24-bit address follows the opcode, and whether the data phase sends bytes from a 64-byte buffer or collects bytes into it.

Software sets up the menu, the type codes, the two prefix opcodes, the flash address and the buffer. It then writes a control word with the start bit set. The block runs one SPI mode-0 cycle with SCLK at a quarter of the system clock. When the atomic option is set, the cycle begins with a prefix opcode sent in its own chip-select frame, for example a write-enable before a program command. While the cycle runs, software polls the status register; when the cycle finishes it clears the sticky bits by writing 1 to them.

The register port has no back-pressure. A write takes effect on the clock edge where `reg_wr_en` is high. Read data is combinational from `reg_addr` and is valid in the same cycle. The SPI pins carry no handshake.

Top module: `spi_menu_seq`

## Requirements
- R1: After reset the status register reads 0, the control register reads 0, `spi_cs_n` is 1 and `spi_sclk` is 0.
- R2: The main frame starts with menu entry `idx`. The menu is two words: word 0x05 holds entries 0 to 3 and word 0x06 holds entries 4 to 7. Entry 0 sits in bits [7:0] of word 0x05. The type of entry n is in bits [2n+1:2n] of register 0x04. Type bit 0 set means write, and type bit 1 set means the address is sent.
- R3: For the two address types, the low 24 bits of register 0x02 follow the opcode, most significant byte first. The other two types send no address byte.
- R4: For write types with data enabled, buffer bytes 0 to count-1 follow the opcode and any address. Byte i is in buffer word i/4 (register 0x10+i/4), at bits [8*(i%4)+7 : 8*(i%4)].
- R5: For read types with data enabled, the block sends 0x00 on MOSI for each of the count data bytes. Each byte received on MISO is written into the buffer with the same byte layout.
- R6: When the data-enable bit is clear, the frame ends after the opcode and any address.
- R7: When the atomic bit is set, the prefix opcode is sent first, alone in its own frame. Prefix select 0 picks bits [7:0] of register 0x03 and select 1 picks bits [15:8]. CS_n then stays high for at least 8 clocks (two SCLK periods) before the main frame starts.
- R8: The SPI pins run in mode 0, MSB first. Each SCLK high phase lasts exactly 2 clocks, and SCLK stays low whenever CS_n is high.
- R9: Status bits are: bit 0 busy, bit 1 done, bit 2 error. Busy rises on an accepted start and falls on the same edge that sets done. Writing 1 to bit 1 or bit 2 clears that bit.
- R10: A control write made while busy is ignored. It does not start a new frame and does not change the control readback.
- R11: A start is rejected in two cases: data is enabled with count-1 above 63, or atomic is set on a read-type entry. A rejected start sets error, leaves busy at 0 and produces no SPI traffic. A count of exactly 64 is accepted.

Control word (register 0x00): bit 0 start, bit 1 atomic, bit 2 prefix select, bit 3 data enable, bits [6:4] menu index, bits [14:8] byte count minus one. Register 0x01 is status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| spi_sclk | output | 1 | SPI clock, clk/4 |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A behavioural flash model captures each chip-select frame and returns a known byte sequence. The bench compares these frames against expected frames built from the menu, type and buffer contents. Each type code is exercised once:
- a no-address read with no data isolates the opcode lookup;
- an address read and an address write of 5, 6 and 64 bytes separate address ordering from buffer byte layout;
- atomic cycles using each prefix select show that the prefix frame and the CS gap are correct.

Rejected starts, a second start while busy, and write-1-to-clear are checked at the status and control registers. The bench also confirms that no frame appears on the pins in those cases.

// File: rtl/spi_menu_seq_pkg.sv
package spi_menu_seq_pkg;
  localparam int unsigned MENU_N = 8;

  localparam logic [4:0] A_CTRL   = 5'h00;
  localparam logic [4:0] A_STAT   = 5'h01;
  localparam logic [4:0] A_FADDR  = 5'h02;
  localparam logic [4:0] A_PREFIX = 5'h03;
  localparam logic [4:0] A_TYPES  = 5'h04;
  localparam logic [4:0] A_MENU0  = 5'h05;
  localparam logic [4:0] A_MENU1  = 5'h06;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_TAIL, PH_GAP, PH_OPC, PH_ADR, PH_DAT
  } seq_phase_t;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int unsigned DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PH_RISE = PW'(DIV/2 - 1);
  localparam logic [PW-1:0] PH_LAST = PW'(DIV - 1);
  localparam logic [PW-1:0] PH_HIGH = PW'(DIV/2);

  logic [PW-1:0] ph;
  logic [2:0]    nbit;
  logic [7:0]    tsh, rsh;
  logic          act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= '0; nbit <= '0; tsh <= '0; rsh <= '0; act <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !act) begin
        act <= 1'b1; ph <= '0; nbit <= '0; tsh <= tx_byte;
      end else if (act) begin
        ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
        if (ph == PH_RISE) rsh <= {rsh[6:0], miso};
        if (ph == PH_LAST) begin
          if (nbit == 3'd7) begin
            act  <= 1'b0;
            done <= 1'b1;
          end else begin
            nbit <= nbit + 1'b1;
            tsh  <= {tsh[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign sclk    = act && (ph >= PH_HIGH);
  assign mosi    = act ? tsh[7] : 1'b0;
  assign rx_byte = rsh;

  // R8: a byte is only launched into an idle shifter
  assert_start_when_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !act);
endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_menu_seq_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 64,
  parameter int unsigned GAP_CYC   = 8,
  localparam int unsigned CW = $clog2(BUF_BYTES),
  localparam int unsigned GW = $clog2(GAP_CYC + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   go,
  input  logic                   atomic,
  input  logic [7:0]             pre_op,
  input  logic [7:0]             main_op,
  input  logic                   with_addr,
  input  logic                   is_write,
  input  logic                   data_en,
  input  logic [CW-1:0]          cnt_m1,
  input  logic [23:0]            flash_addr,
  input  logic [BUF_BYTES*8-1:0] buf_flat,
  input  logic                   eng_done,
  input  logic [7:0]             eng_rx,
  output logic                   eng_start,
  output logic [7:0]             eng_tx,
  output logic                   cs_n,
  output logic                   wr_en,
  output logic [CW-1:0]          wr_idx,
  output logic [7:0]             wr_byte,
  output logic                   cyc_done
);
  seq_phase_t     ph;
  logic [CW-1:0]  k, last_q;
  logic [GW-1:0]  gcnt;
  logic [7:0]     op_q;
  logic [23:0]    adr_q;
  logic           wa_q, wr_q, den_q, pre_pend;

  function automatic logic [7:0] data_byte(input logic [CW-1:0] i, input logic wrt);
    return wrt ? buf_flat[{i, 3'b000} +: 8] : 8'h00;
  endfunction

  function automatic logic [7:0] addr_byte(input logic [CW-1:0] i);
    case (i)
      CW'(0):  return adr_q[23:16];
      CW'(1):  return adr_q[15:8];
      default: return adr_q[7:0];
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_IDLE; k <= '0; last_q <= '0; gcnt <= '0; op_q <= '0; adr_q <= '0;
      wa_q <= 1'b0; wr_q <= 1'b0; den_q <= 1'b0; pre_pend <= 1'b0;
      eng_start <= 1'b0; eng_tx <= '0; cs_n <= 1'b1;
      wr_en <= 1'b0; wr_idx <= '0; wr_byte <= '0; cyc_done <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      wr_en     <= 1'b0;
      cyc_done  <= 1'b0;
      case (ph)
        PH_IDLE: if (go) begin
          op_q <= main_op; adr_q <= flash_addr; wa_q <= with_addr; wr_q <= is_write;
          den_q <= data_en; last_q <= cnt_m1; pre_pend <= atomic;
          cs_n <= 1'b0; eng_start <= 1'b1;
          eng_tx <= atomic ? pre_op : main_op;
          ph <= atomic ? PH_PRE : PH_OPC;
        end
        PH_PRE: if (eng_done) ph <= PH_TAIL;
        PH_TAIL: begin
          cs_n <= 1'b1;
          if (pre_pend) begin
            pre_pend <= 1'b0; gcnt <= '0; ph <= PH_GAP;
          end else begin
            cyc_done <= 1'b1; ph <= PH_IDLE;
          end
        end
        PH_GAP: begin
          if (gcnt == GW'(GAP_CYC - 1)) begin
            cs_n <= 1'b0; eng_start <= 1'b1; eng_tx <= op_q; ph <= PH_OPC;
          end else gcnt <= gcnt + 1'b1;
        end
        PH_OPC: if (eng_done) begin
          k <= '0;
          if (wa_q) begin
            eng_start <= 1'b1; eng_tx <= addr_byte('0); ph <= PH_ADR;
          end else if (den_q) begin
            eng_start <= 1'b1; eng_tx <= data_byte('0, wr_q); ph <= PH_DAT;
          end else ph <= PH_TAIL;
        end
        PH_ADR: if (eng_done) begin
          if (k == CW'(2)) begin
            k <= '0;
            if (den_q) begin
              eng_start <= 1'b1; eng_tx <= data_byte('0, wr_q); ph <= PH_DAT;
            end else ph <= PH_TAIL;
          end else begin
            k <= k + 1'b1; eng_start <= 1'b1; eng_tx <= addr_byte(k + 1'b1);
          end
        end
        PH_DAT: if (eng_done) begin
          if (!wr_q) begin
            wr_en <= 1'b1; wr_idx <= k; wr_byte <= eng_rx;
          end
          if (k == last_q) ph <= PH_TAIL;
          else begin
            k <= k + 1'b1; eng_start <= 1'b1; eng_tx <= data_byte(k + 1'b1, wr_q);
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R8: every byte is shifted inside an open frame
  assert_shift_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !cs_n);
  // R5: buffer updates only come from read-type cycles
  assert_fill_only_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !wr_q);
  // R7: the prefix gap keeps the select deasserted
  assert_gap_cs_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_GAP) |-> cs_n);
endmodule

// File: rtl/spi_menu_seq.sv
module spi_menu_seq
  import spi_menu_seq_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 64,
  parameter int unsigned DIV       = 4,
  parameter int unsigned GAP_SCLK  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int unsigned BUF_WORDS = BUF_BYTES / 4;
  localparam int unsigned CW        = $clog2(BUF_BYTES);
  localparam int unsigned NW        = CW + 1;
  localparam int unsigned TIW       = $clog2(MENU_N);
  localparam int unsigned GAP_CYC   = GAP_SCLK * DIV;
  localparam int unsigned WW        = $clog2(BUF_WORDS);

  logic [NW+6:0]           ctrl_q;
  logic [23:0]             faddr_q;
  logic [15:0]             prefix_q;
  logic [2*MENU_N-1:0]     types_q;
  logic [8*MENU_N-1:0]     menu_q;
  logic [31:0]             buf_w [BUF_WORDS];
  logic [BUF_BYTES*8-1:0]  buf_flat;
  logic                    busy_q, done_q, err_q;

  logic                    eng_start, eng_done, cyc_done, fill_en;
  logic [7:0]              eng_tx, eng_rx, fill_byte;
  logic [CW-1:0]           fill_idx;

  for (genvar w = 0; w < BUF_WORDS; w++) begin : g_flat
    assign buf_flat[w*32 +: 32] = buf_w[w];
  end

  logic           wr_ctrl, start_req, bad, go;
  logic [TIW-1:0] sel_idx;
  logic [1:0]     sel_type;

  assign wr_ctrl   = reg_wr_en && (reg_addr == A_CTRL);
  assign start_req = wr_ctrl && reg_wdata[0] && !busy_q;
  assign sel_idx   = reg_wdata[4 +: TIW];
  assign sel_type  = types_q[{sel_idx, 1'b0} +: 2];
  assign bad       = (reg_wdata[3] && (reg_wdata[8 +: NW] > NW'(BUF_BYTES - 1)))
                   || (reg_wdata[1] && !sel_type[0]);
  assign go        = start_req && !bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0; faddr_q <= '0; prefix_q <= '0; types_q <= '0; menu_q <= '0;
      busy_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      for (int w = 0; w < BUF_WORDS; w++) buf_w[w] <= '0;
    end else begin
      if (go) busy_q <= 1'b1;
      else if (cyc_done) busy_q <= 1'b0;

      if (cyc_done) done_q <= 1'b1;
      else if (reg_wr_en && reg_addr == A_STAT && reg_wdata[1]) done_q <= 1'b0;

      if (start_req && bad) err_q <= 1'b1;
      else if (reg_wr_en && reg_addr == A_STAT && reg_wdata[2]) err_q <= 1'b0;

      if (wr_ctrl && !busy_q) ctrl_q <= reg_wdata[NW+7:1];

      if (reg_wr_en) begin
        case (reg_addr)
          A_FADDR:  faddr_q  <= reg_wdata[23:0];
          A_PREFIX: prefix_q <= reg_wdata[15:0];
          A_TYPES:  types_q  <= reg_wdata[15:0];
          A_MENU0:  menu_q[31:0]  <= reg_wdata;
          A_MENU1:  menu_q[63:32] <= reg_wdata;
          default: if (reg_addr[4]) buf_w[reg_addr[WW-1:0]] <= reg_wdata;
        endcase
      end
      if (fill_en) buf_w[fill_idx[CW-1:2]][{fill_idx[1:0], 3'b000} +: 8] <= fill_byte;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:   reg_rdata[NW+7:1] = ctrl_q;
      A_STAT:   reg_rdata[2:0]    = {err_q, done_q, busy_q};
      A_FADDR:  reg_rdata[23:0]   = faddr_q;
      A_PREFIX: reg_rdata[15:0]   = prefix_q;
      A_TYPES:  reg_rdata[15:0]   = types_q;
      A_MENU0:  reg_rdata         = menu_q[31:0];
      A_MENU1:  reg_rdata         = menu_q[63:32];
      default:  if (reg_addr[4]) reg_rdata = buf_w[reg_addr[WW-1:0]];
    endcase
  end

  spi_seq_ctrl #(.BUF_BYTES(BUF_BYTES), .GAP_CYC(GAP_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go), .atomic(reg_wdata[1]),
    .pre_op(reg_wdata[2] ? prefix_q[15:8] : prefix_q[7:0]),
    .main_op(menu_q[{sel_idx, 3'b000} +: 8]),
    .with_addr(sel_type[1]), .is_write(sel_type[0]), .data_en(reg_wdata[3]),
    .cnt_m1(reg_wdata[8 +: CW]), .flash_addr(faddr_q), .buf_flat(buf_flat),
    .eng_done(eng_done), .eng_rx(eng_rx), .eng_start(eng_start), .eng_tx(eng_tx),
    .cs_n(spi_cs_n), .wr_en(fill_en), .wr_idx(fill_idx), .wr_byte(fill_byte),
    .cyc_done(cyc_done)
  );

  spi_byte_shifter #(.DIV(DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .tx_byte(eng_tx), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .done(eng_done), .rx_byte(eng_rx)
  );

  // R8: clock is parked low outside frames
  assert_idle_clock_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  // R11: a rejected start never opens a frame
  assert_reject_no_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && bad) |=> (!busy_q && spi_cs_n));
  // R9: busy only drops together with done
  assert_busy_ends_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  // R10: control writes during a cycle leave the control word alone
  assert_ctrl_frozen_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && busy_q) |=> $stable(ctrl_q));
endmodule

// File: tb/spi_menu_seq_tb.sv
module spi_menu_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int checks = 0, failures = 0, cyc = 0;

  spi_menu_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #5 clk = ~clk;

  // ---------------- behavioural flash model ----------------
  logic [7:0] resp [0:127];
  logic [7:0] cap_q[$];
  int         len_q[$];
  int         gap_q[$];
  logic [7:0] cur = '0;
  int         sb = 0, fr_cnt = 0;
  bit         in_frame = 0;

  always @(negedge spi_cs_n) begin
    in_frame = 1; sb = 0; fr_cnt = 0;
    spi_miso = resp[0][7];
  end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    cur = {cur[6:0], spi_mosi};
    sb++;
    if (sb % 8 == 0) begin cap_q.push_back(cur); fr_cnt++; end
  end
  always @(negedge spi_sclk) if (!spi_cs_n) spi_miso = resp[sb/8][7 - (sb%8)];
  always @(posedge spi_cs_n) if (in_frame) begin
    in_frame = 0; len_q.push_back(fr_cnt);
  end

  // ---------------- per-clock pin monitor (R8, R7) ----------------
  int hi_run = 0, cs_hi = 0, pin_bad = 0;
  always @(negedge clk) if (rst_n) begin
    if (spi_cs_n && spi_sclk) pin_bad++;
    if (spi_sclk) hi_run++;
    else begin
      if (hi_run != 0 && hi_run != 2) pin_bad++;
      hi_run = 0;
    end
    if (spi_cs_n) cs_hi++;
    else begin
      if (cs_hi != 0) gap_q.push_back(cs_hi);
      cs_hi = 0;
    end
  end

  // ---------------- helpers ----------------
  logic [7:0] exp_b[$];
  int         exp_l[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [31:0] cw(input bit st, input bit at, input bit ps,
                                     input bit de, input int idx, input int cnt);
    return (32'(cnt - 1) << 8) | (32'(idx) << 4) | (32'(de) << 3) | (32'(ps) << 2)
         | (32'(at) << 1) | 32'(st);
  endfunction

  function automatic logic [7:0] bpat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  task automatic clear_caps();
    cap_q.delete(); len_q.delete(); gap_q.delete(); exp_b.delete(); exp_l.delete();
  endtask

  task automatic wait_end(input string tag);
    logic [31:0] s;
    int n = 0;
    do begin rd(5'h01, s); n++; end while (!(s[1] | s[2]) && n < 3000);
    chk(n < 3000, {tag, " cycle completes"}, n, 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic cmp_frames(input string tag);
    int p = 0;
    bit ok = 1;
    int bad_at = -1;
    chk(len_q.size() == exp_l.size(), {tag, " frame count"}, len_q.size(), exp_l.size());
    if (len_q.size() == exp_l.size()) begin
      for (int f = 0; f < exp_l.size(); f++)
        if (len_q[f] != exp_l[f]) begin ok = 0; bad_at = f; end
      chk(ok, {tag, " frame lengths"}, bad_at < 0 ? 0 : len_q[bad_at],
          bad_at < 0 ? 0 : exp_l[bad_at]);
      if (ok) begin
        for (int i = 0; i < exp_b.size(); i++) begin
          if (cap_q[i] != exp_b[i] && p == 0) begin
            p = 1;
            chk(0, {tag, " frame byte"}, cap_q[i], exp_b[i]);
          end
        end
        if (p == 0) chk(1, {tag, " frame bytes"}, 0, 0);
      end
    end
  endtask

  task automatic clr_status();
    wr(5'h01, 32'h6);
  endtask

  logic [31:0] r;

  initial begin : watchdog
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    for (int j = 0; j < 128; j++) resp[j] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h01, r); chk(r == 0, "R1 status after reset", r, 0);
    rd(5'h00, r); chk(r == 0, "R1 control after reset", r, 0);
    chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1 idle pins", {spi_cs_n, spi_sclk}, 2'b10);

    // configuration: menu, types (bit0 write, bit1 address), prefixes, address
    wr(5'h05, 32'h05D80302);
    wr(5'h06, 32'hC79F0190);
    wr(5'h04, 32'h0000463B);
    wr(5'h03, 32'h00005006);
    wr(5'h02, 32'hAB12CDEF);

    // T1: R2 R6 opcode only, type 0 entry 6
    clear_caps();
    wr(5'h00, cw(1, 0, 0, 0, 6, 1));
    rd(5'h01, r); chk(r[0] == 1'b1, "R9 busy after start", r, 1);
    wait_end("R2");
    rd(5'h01, r); chk(r == 32'h2, "R9 done set busy clear", r, 2);
    exp_b.push_back(8'h9F); exp_l.push_back(1);
    cmp_frames("R2 R6 opcode-only");
    clr_status();
    rd(5'h01, r); chk(r == 0, "R9 done write-1-clear", r, 0);

    // T2: R3 R5 address read of 5 bytes
    clear_caps();
    for (int j = 0; j < 128; j++) resp[j] = 8'((j * 13 + 8'h40) & 255);
    wr(5'h00, cw(1, 0, 0, 1, 1, 5));
    wait_end("R5");
    exp_b = '{8'h03, 8'h12, 8'hCD, 8'hEF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    exp_l.push_back(9);
    cmp_frames("R3 R5 read with address");
    rd(5'h10, r); chk(r == {resp[7], resp[6], resp[5], resp[4]}, "R5 buffer word0", r,
                      {resp[7], resp[6], resp[5], resp[4]});
    rd(5'h11, r); chk(r == {24'h0, resp[8]}, "R5 buffer word1", r, {24'h0, resp[8]});
    clr_status();

    // load write pattern
    for (int w = 0; w < 16; w++)
      wr(5'(16 + w), {bpat(4*w+3), bpat(4*w+2), bpat(4*w+1), bpat(4*w)});

    // T3: R7 R4 atomic prefix 0 + write with address, 6 bytes
    clear_caps();
    wr(5'h00, cw(1, 1, 0, 1, 0, 6));
    wait_end("R7");
    exp_b = '{8'h06, 8'h02, 8'h12, 8'hCD, 8'hEF};
    for (int i = 0; i < 6; i++) exp_b.push_back(bpat(i));
    exp_l = '{1, 10};
    cmp_frames("R7 R4 atomic write");
    chk(gap_q.size() >= 2 && gap_q[1] >= 8, "R7 CS gap >= 2 SCLK",
        gap_q.size() >= 2 ? gap_q[1] : -1, 8);
    clr_status();

    // T4: R7 prefix 1 + write without address, 2 bytes
    clear_caps();
    wr(5'h00, cw(1, 1, 1, 1, 5, 2));
    wait_end("R7b");
    exp_b = '{8'h50, 8'h01, bpat(0), bpat(1)};
    exp_l = '{1, 3};
    cmp_frames("R7 prefix select 1");
    clr_status();

    // T5: R4 full 64-byte write with address (boundary)
    clear_caps();
    wr(5'h00, cw(1, 0, 0, 1, 2, 64));
    wait_end("R4");
    rd(5'h01, r); chk(r == 32'h2, "R11 count 64 accepted", r, 2);
    exp_b = '{8'hD8, 8'h12, 8'hCD, 8'hEF};
    for (int i = 0; i < 64; i++) exp_b.push_back(bpat(i));
    exp_l = '{68};
    cmp_frames("R4 64-byte write");
    clr_status();

    // T6: R5 full 64-byte read
    clear_caps();
    for (int j = 0; j < 128; j++) resp[j] = 8'((j * 29 + 7) & 255);
    wr(5'h00, cw(1, 0, 0, 1, 4, 64));
    wait_end("R5b");
    exp_b = '{8'h90, 8'h12, 8'hCD, 8'hEF};
    for (int i = 0; i < 64; i++) exp_b.push_back(8'h00);
    exp_l = '{68};
    cmp_frames("R5 64-byte read MOSI");
    begin
      int bad_w = -1;
      logic [31:0] ev = '0, got = '0;
      for (int w = 0; w < 16; w++) begin
        logic [31:0] e;
        e = {resp[4+4*w+3], resp[4+4*w+2], resp[4+4*w+1], resp[4+4*w]};
        rd(5'(16 + w), r);
        if (r != e && bad_w < 0) begin bad_w = w; ev = e; got = r; end
      end
      chk(bad_w < 0, "R5 64-byte buffer fill", got, ev);
    end
    clr_status();

    // T7: R10 start while busy ignored
    clear_caps();
    wr(5'h00, cw(1, 0, 0, 0, 6, 1));
    wr(5'h00, cw(1, 0, 0, 0, 3, 1));
    wait_end("R10");
    repeat (100) @(negedge clk);
    exp_b = '{8'h9F}; exp_l = '{1};
    cmp_frames("R10 second start ignored");
    rd(5'h00, r); chk(r == (cw(1, 0, 0, 0, 6, 1) & 32'hFFFE), "R10 control readback", r,
                      cw(1, 0, 0, 0, 6, 1) & 32'hFFFE);
    clr_status();

    // T8: R11 count 65 rejected
    clear_caps();
    wr(5'h00, cw(1, 0, 0, 1, 0, 65));
    rd(5'h01, r); chk(r == 32'h4, "R11 oversize count error", r, 4);
    repeat (60) @(negedge clk);
    chk(len_q.size() == 0 && cap_q.size() == 0, "R11 no traffic on oversize",
        len_q.size(), 0);
    clr_status();
    rd(5'h01, r); chk(r == 0, "R9 error write-1-clear", r, 0);

    // T9: R11 atomic on read types rejected
    clear_caps();
    wr(5'h00, cw(1, 1, 0, 0, 3, 1));
    rd(5'h01, r); chk(r == 32'h4, "R11 atomic on read no-address", r, 4);
    clr_status();
    wr(5'h00, cw(1, 1, 1, 1, 1, 4));
    rd(5'h01, r); chk(r == 32'h4, "R11 atomic on read with address", r, 4);
    repeat (60) @(negedge clk);
    chk(len_q.size() == 0, "R11 no traffic on atomic read", len_q.size(), 0);
    clr_status();

    // R8 aggregate pin discipline
    chk(pin_bad == 0, "R8 SCLK high 2 clocks, low outside frames", pin_bad, 0);
    chk(spi_cs_n === 1'b1, "R1 idle at end", spi_cs_n, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule